// File: doc/BRIEF.md
# Triple Programmable Interval Timer

This peripheral holds three independent 16-bit down-counters behind an 8-bit register interface. Each counter has its own clock input, its own active-low gate and its own output pin. Each reloads from a 16-bit reload register whenever it expires, and its output pin toggles on every expiry. The result is a continuous square wave whose frequency is the count clock divided by 2×(N+1), where N is the reload value. A counter can also run as two cascaded 8-bit halves. In that case one expiry takes (H+1)×(L+1) count ticks, where H is the high byte and L is the low byte of the reload value.

Software sees eight byte addresses. A 16-bit reload value goes in as two bytes. The high byte is parked in a single staging byte that all three timers share. The low-byte write then moves the staging byte and the low byte into that timer's reload register in one step. The first and third timers share one control address, and bit 0 of the second timer's control byte steers which of the two it reaches. Bit 0 of the first timer's control byte holds all three timers in reset. Expiry flags appear in a status byte and drive an active-low interrupt line.

All logic runs on one system clock `clk`. The external count clocks and gates are synchronised into that domain. A count clock counts on its synchronised rising edge.

Top module: `ptm_triple_timer`

## Requirements
- R1: A write to address 2, 4 or 6 stores the byte in one staging byte shared by all timers. A write to address 3 (timer 1), 5 (timer 2) or 7 (timer 3) loads that timer's reload register with {staging byte, written byte}, even if a different timer's high address filled the staging byte.
- R2: A write to address 0 reaches timer 1's control byte when bit 0 of timer 2's control byte (address 1) is 1. It reaches timer 3's control byte when that bit is 0.
- R3: After `rst_n` and whenever bit 0 of timer 1's control byte is 1, all timers hold their count, their outputs are 0 and their flags are 0. A reload write made in this state also loads the counter. After `rst_n` every counter and reload register is 0xFFFF, that hold bit is 1, the other control bits are 0, the status reads 0 and `irq_n` is 1.
- R4: Control byte layout: bit 7 output enable, bit 6 interrupt enable, bits 5:3 operating mode (000 = continuous), bit 2 counting mode (0 = 16-bit), bit 1 clock select (1 = `clk`). With these settings a running counter with reload N expires once every N+1 ticks, reloads and toggles its output. A reload of 0 toggles on every tick.
- R5: With bit 2 = 1 (dual 8-bit), the low byte counts down and reloads from the low reload byte each time the high byte steps down. Expiry happens when both bytes are zero, so it occurs every (H+1)×(L+1) ticks.
- R6: With clock select 0, a counter steps once per rising edge of its own `tmr_clk` bit and does not move otherwise.
- R7: While a timer's `tmr_gate_n` bit is high, its counter does not change.
- R8: Reading address 1 returns the status byte. Bits 0, 1 and 2 are the expiry flags of timers 1, 2 and 3. Bit 7 is set when any flag whose interrupt enable is 1 is set. Bits 6:3 read 0. A flag sets on every expiry.
- R9: A flag clears only when a status read taken while the flag was set is later followed by a read of that timer's high counter address. A counter read without such a preceding status read leaves the flag set.
- R10: `irq_n` is 0 exactly when status bit 7 is 1. A flag whose interrupt enable is 0 never pulls `irq_n` low.
- R11: A timer's output pin stays 0 while its output enable bit is 0.
- R12: Reading address 2, 4 or 6 returns the high byte of that live counter and copies its low byte into the staging byte. Reading address 3, 5 or 7 returns the staging byte.
- R13: An operating mode other than 000 freezes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one access per cycle it is high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read access, 0 otherwise |
| irq_n | output | 1 | Active-low interrupt request |
| tmr_clk | input | 3 | External count clocks, one per timer |
| tmr_gate_n | input | 3 | Active-low gates; high suspends counting |
| tmr_out | output | 3 | Square-wave outputs |

## Verification
Several properties are checked on every cycle:
- a counter does not move under hold, gate or a non-continuous mode;
- an expiry reloads the counter from its reload register, and the output changes only on an expiry;
- a flag falls only through the armed clear path;
- a low-byte write assembles the reload from the shared staging byte;
- a write to address 0 with the steering bit low leaves timer 1's control byte alone.

Only the bench's scenarios can show the things that depend on elapsed time and on access order:
- the exact toggle periods in both counting modes, including a reload of zero;
- counting on external edges;
- the status-then-counter clear order;
- the interrupt line with interrupt enable both on and off.

// File: rtl/ptm_pkg.sv
// ptm_pkg: shared widths, control byte layout and mode codes for the triple
// interval timer. Assumes an 8-bit host bus and 16-bit counters.
package ptm_pkg;
    localparam int NUM_TMR = 3;
    localparam int CNT_W   = 16;
    localparam int BUS_W   = CNT_W / 2;

    // Control byte, most significant field first (bit 7 .. bit 0).
    typedef struct packed {
        logic       out_en;   // bit 7
        logic       irq_en;   // bit 6
        logic [2:0] op_mode;  // bits 5:3
        logic       dual8;    // bit 2
        logic       int_clk;  // bit 1
        logic       special;  // bit 0: hold (timer 1) / steering (timer 2)
    } tmr_ctrl_t;

    localparam logic [2:0] MODE_CONT = 3'b000;
endpackage

// File: rtl/ptm_in_sync.sv
// ptm_in_sync: multi-stage synchroniser for asynchronous per-timer inputs.
// Assumes inputs are slow relative to clk; reset value of every stage is 0.
module ptm_in_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/ptm_timer_chan.sv
// ptm_timer_chan: one 16-bit down-counter with continuous reload, square
// wave output and expiry flag. Supports 16-bit and dual 8-bit counting.
// Assumes ext_lvl and gate_hi are already synchronised to clk.
module ptm_timer_chan #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          int_clk,
    input  logic          dual8,
    input  logic [2:0]    op_mode,
    input  logic          out_en,
    input  logic          ext_lvl,
    input  logic          gate_hi,
    input  logic [CW-1:0] latch_val,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          flag_clr,
    output logic [CW-1:0] count,
    output logic          tout,
    output logic          flag
);
    import ptm_pkg::*;

    localparam int HW = CW / 2;
    localparam logic [CW-1:0] ONE_F = CW'(1);
    localparam logic [HW-1:0] ONE_H = HW'(1);

    logic [CW-1:0] count_q, count_d;
    logic          out_q, flag_q, ext_prev_q;
    logic          tick, run, expire, low_empty;

    assign tick      = int_clk | (ext_lvl & ~ext_prev_q);
    assign run       = !hold && !gate_hi && (op_mode == MODE_CONT) && tick;
    assign expire    = run && (count_q == '0);
    assign low_empty = (count_q[HW-1:0] == '0);

    // Next count: reload under hold, otherwise decrement or reload on expiry.
    always_comb begin
        count_d = count_q;
        if (hold) begin
            if (load_en) count_d = load_val;
        end else if (run) begin
            if (expire)
                count_d = latch_val;
            else if (dual8 && low_empty)
                count_d = {count_q[CW-1:HW] - ONE_H, latch_val[HW-1:0]};
            else
                count_d = count_q - ONE_F;
        end
    end

    // Register count, output phase, expiry flag and external clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= '1;
            out_q      <= 1'b0;
            flag_q     <= 1'b0;
            ext_prev_q <= 1'b0;
        end else begin
            count_q    <= count_d;
            ext_prev_q <= ext_lvl;
            if (hold) begin
                out_q  <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                if (expire) out_q <= ~out_q;
                if (expire)        flag_q <= 1'b1;
                else if (flag_clr) flag_q <= 1'b0;
            end
        end
    end

    assign count = count_q;
    assign tout  = out_q & out_en;
    assign flag  = flag_q;

    // R3
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load_en) |=> $stable(count_q));
    // R7
    gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && gate_hi) |=> $stable(count_q));
    // R13
    mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && op_mode != MODE_CONT) |=> $stable(count_q));
    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count_q == '0) |=> (count_q == $past(latch_val)));
    // R4
    toggle_only_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !expire) |=> $stable(out_q));
    // R9
    flag_clear_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_q) && !$past(hold)) |-> $past(flag_clr));
endmodule

// File: rtl/ptm_bus_regs.sv
// ptm_bus_regs: host-side register file. Decodes the eight byte addresses,
// holds control bytes, reload registers, the shared staging byte and the
// flag-clear arming bits; forms read data, status and interrupt.
// Assumes one access per cycle with bus_en high; reads take effect at the edge.
module ptm_bus_regs
    import ptm_pkg::*;
#(
    parameter int NT = NUM_TMR,
    parameter int CW = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_rw,
    input  logic [2:0]       bus_rs,
    input  logic [CW/2-1:0]  bus_wdata,
    output logic [CW/2-1:0]  bus_rdata,
    output logic             irq_n,
    input  logic [CW-1:0]    count [NT],
    input  logic [NT-1:0]    flags,
    output tmr_ctrl_t        ctrl [NT],
    output logic             hold,
    output logic [CW-1:0]    latch [NT],
    output logic [NT-1:0]    load_en,
    output logic [CW-1:0]    load_val,
    output logic [NT-1:0]    flag_clr
);
    localparam int HW = CW / 2;

    tmr_ctrl_t     cr_q [NT];
    logic [CW-1:0] latch_q [NT];
    logic [HW-1:0] stage_q;
    logic [NT-1:0] arm_q, arm_d;
    logic [NT-1:0] ien, wr_hi, wr_lo, rd_hi, rd_lo;
    logic          wr, rd, comp;
    logic [HW-1:0] status;

    assign wr = bus_en & ~bus_rw;
    assign rd = bus_en &  bus_rw;

    // Per-timer address hits for the high and low byte addresses.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            wr_hi[t] = wr && (bus_rs[2:1] == 2'(t + 1)) && !bus_rs[0];
            wr_lo[t] = wr && (bus_rs[2:1] == 2'(t + 1)) &&  bus_rs[0];
            rd_hi[t] = rd && (bus_rs[2:1] == 2'(t + 1)) && !bus_rs[0];
            rd_lo[t] = rd && (bus_rs[2:1] == 2'(t + 1)) &&  bus_rs[0];
            ien[t]   = cr_q[t].irq_en;
        end
    end

    assign comp     = |(flags & ien);
    assign status   = {comp, {(HW - 1 - NT){1'b0}}, flags};
    assign irq_n    = ~comp;
    assign load_val = {stage_q, bus_wdata};
    assign load_en  = wr_lo;
    assign flag_clr = rd_hi & arm_q;
    assign hold     = cr_q[0].special;

    // Arming: a status read snapshots the flags, a counter read consumes one.
    always_comb begin
        arm_d = arm_q;
        if (rd && bus_rs == 3'd1) arm_d = flags;
        for (int t = 0; t < NT; t++)
            if (rd_hi[t]) arm_d[t] = 1'b0;
    end

    // Register writes, staging byte capture and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                cr_q[t]    <= '0;
                latch_q[t] <= '1;
            end
            cr_q[0].special <= 1'b1;
            stage_q <= '0;
            arm_q   <= '0;
        end else begin
            arm_q <= arm_d;
            if (wr && bus_rs == 3'd0) begin
                if (cr_q[1].special) cr_q[0]    <= tmr_ctrl_t'(bus_wdata);
                else                 cr_q[NT-1] <= tmr_ctrl_t'(bus_wdata);
            end
            if (wr && bus_rs == 3'd1) cr_q[1] <= tmr_ctrl_t'(bus_wdata);
            for (int t = 0; t < NT; t++) begin
                if (wr_hi[t]) stage_q    <= bus_wdata;
                if (rd_hi[t]) stage_q    <= count[t][HW-1:0];
                if (wr_lo[t]) latch_q[t] <= {stage_q, bus_wdata};
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd && bus_rs == 3'd1) bus_rdata = status;
        for (int t = 0; t < NT; t++) begin
            if (rd_hi[t]) bus_rdata = count[t][CW-1:HW];
            if (rd_lo[t]) bus_rdata = stage_q;
        end
    end

    assign ctrl  = cr_q;
    assign latch = latch_q;

    generate
        for (genvar g = 0; g < NT; g++) begin : g_latch_chk
            // R1
            latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo[g] |=> (latch_q[g] == $past({stage_q, bus_wdata})));
        end
    endgenerate

    // R2
    route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_rs == 3'd0 && !cr_q[1].special) |=> $stable(cr_q[0]));
endmodule

// File: rtl/ptm_triple_timer.sv
// ptm_triple_timer: top level of the triple interval timer. Synchronises
// the external clocks and gates, instantiates the register file and one
// counter channel per timer. Assumes all bus signals are synchronous to clk.
module ptm_triple_timer
    import ptm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_rw,
    input  logic [2:0]          bus_rs,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                irq_n,
    input  logic [NUM_TMR-1:0]  tmr_clk,
    input  logic [NUM_TMR-1:0]  tmr_gate_n,
    output logic [NUM_TMR-1:0]  tmr_out
);
    logic [NUM_TMR-1:0] clk_s, gate_s, flags, load_en, flag_clr;
    logic [CNT_W-1:0]   count [NUM_TMR];
    logic [CNT_W-1:0]   latch [NUM_TMR];
    logic [CNT_W-1:0]   load_val;
    tmr_ctrl_t          ctrl  [NUM_TMR];
    logic               hold;

    ptm_in_sync #(.W(2 * NUM_TMR), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   ({tmr_gate_n, tmr_clk}),
        .d_sync ({gate_s, clk_s})
    );

    ptm_bus_regs #(.NT(NUM_TMR), .CW(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_rw    (bus_rw),
        .bus_rs    (bus_rs),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n),
        .count     (count),
        .flags     (flags),
        .ctrl      (ctrl),
        .hold      (hold),
        .latch     (latch),
        .load_en   (load_en),
        .load_val  (load_val),
        .flag_clr  (flag_clr)
    );

    generate
        for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
            ptm_timer_chan #(.CW(CNT_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .hold      (hold),
                .int_clk   (ctrl[g].int_clk),
                .dual8     (ctrl[g].dual8),
                .op_mode   (ctrl[g].op_mode),
                .out_en    (ctrl[g].out_en),
                .ext_lvl   (clk_s[g]),
                .gate_hi   (gate_s[g]),
                .latch_val (latch[g]),
                .load_en   (load_en[g]),
                .load_val  (load_val),
                .flag_clr  (flag_clr[g]),
                .count     (count[g]),
                .tout      (tmr_out[g]),
                .flag      (flags[g])
            );
        end
    endgenerate

    // R11
    out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0].out_en) |-> !tmr_out[0]);
endmodule

// File: tb/tb_ptm_triple_timer.sv
`timescale 1ns/1ps
module tb_ptm_triple_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_rw = 1'b0;
    logic [2:0] bus_rs = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n;
    logic [2:0] tmr_clk = '0, tmr_gate_n = '0, tmr_out;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    ptm_triple_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rw(bus_rw),
        .bus_rs(bus_rs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .tmr_clk(tmr_clk), .tmr_gate_n(tmr_gate_n),
        .tmr_out(tmr_out)
    );

    // Vector: {reload[15:0], dual8, expected ticks per toggle[15:0]}
    localparam int NV = 5;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0003, 1'b0, 16'd4},
        {16'h0000, 1'b0, 16'd1},
        {16'h0010, 1'b0, 16'd17},
        {16'h0102, 1'b1, 16'd6},
        {16'h0300, 1'b1, 16'd4}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_rw = 1'b0; bus_rs = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_rw = 1'b1; bus_rs = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] hi, lo, v1h, v1l, v2h, v2l;
        logic       seen_t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3 reset state
        chk("R3 tout after reset", {13'd0, tmr_out}, 16'h0);
        chk("R3 irq_n after reset", {15'd0, irq_n}, 16'h1);
        rd(3'd1, lo); chk("R3/R8 status after reset", {8'd0, lo}, 16'h00);
        rd(3'd2, hi); rd(3'd3, lo);
        chk("R3/R12 counter after reset", {hi, lo}, 16'hFFFF);

        // R1 shared staging byte, reload in hold loads counter
        wr(3'd2, 8'h12); wr(3'd3, 8'h34);
        rd(3'd2, hi); rd(3'd3, lo);
        chk("R1 timer1 load", {hi, lo}, 16'h1234);
        wr(3'd4, 8'hAB); wr(3'd3, 8'h56);
        rd(3'd2, hi); rd(3'd3, lo);
        chk("R1 shared staging across timers", {hi, lo}, 16'hAB56);

        // R2 steering bit 0 routes address 0 to timer 3
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h82);          // to timer 3: output on, internal clock
        wr(3'd6, 8'h00); wr(3'd7, 8'h01);
        seen_t2 = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tmr_out[2]) seen_t2 = 1'b1;
        end
        chk("R2/R3 write did not release hold", {15'd0, seen_t2}, 16'h0);
        wr(3'd1, 8'h01);          // steering to timer 1, timer 2 external idle

        // R4/R5 vector table on timer 1
        for (int v = 0; v < NV; v++) begin
            logic [15:0] rl, half;
            logic        dm, prev, prev3;
            int          t1, t2, t3;
            rl = VEC[v][32:17]; dm = VEC[v][16]; half = VEC[v][15:0];
            wr(3'd0, 8'h83 | {5'd0, dm, 2'd0});
            wr(3'd2, rl[15:8]); wr(3'd3, rl[7:0]);
            wr(3'd0, 8'h82 | {5'd0, dm, 2'd0});
            t1 = 0; t2 = 0; t3 = 0; prev = 1'b0; prev3 = 1'b0;
            for (int k = 1; k <= 4 * half + 10; k++) begin
                @(negedge clk);
                if (tmr_out[0] != prev) begin
                    if (t1 == 0) t1 = k; else if (t2 == 0) t2 = k;
                end
                if (tmr_out[2] != prev3 && t3 == 0) t3 = k;
                prev = tmr_out[0]; prev3 = tmr_out[2];
            end
            if (dm) begin
                chk("R5 dual8 first toggle", 16'(t1), half);
                chk("R5 dual8 second toggle", 16'(t2), 16'(2 * half));
            end else begin
                chk("R4 first toggle", 16'(t1), half);
                chk("R4 second toggle", 16'(t2), 16'(2 * half));
            end
            if (v == 0) chk("R2 timer3 got control byte", 16'(t3), 16'd2);
        end

        // Flags, interrupt, clear order
        wr(3'd0, 8'h83);          // hold all
        wr(3'd1, 8'h02);          // steer to timer 3, timer 2 internal, OE=0 IE=0
        wr(3'd0, 8'h00);          // timer 3 idle
        wr(3'd1, 8'h03);          // steer back to timer 1
        wr(3'd0, 8'hC3);          // timer 1 OE, IE, internal, hold
        wr(3'd2, 8'h00); wr(3'd3, 8'h03);
        wr(3'd4, 8'h00); wr(3'd5, 8'h02);
        wr(3'd0, 8'hC2);          // start
        seen_t2 = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tmr_out[1]) seen_t2 = 1'b1;
        end
        tmr_gate_n = 3'b011;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tmr_out[1]) seen_t2 = 1'b1;
        end
        chk("R11 masked output stays low", {15'd0, seen_t2}, 16'h0);
        chk("R10 irq asserted", {15'd0, irq_n}, 16'h0);
        rd(3'd2, hi);             // not armed: must not clear
        rd(3'd1, lo);
        chk("R8/R9 status, unarmed read kept flag", {8'd0, lo}, 16'h83);
        rd(3'd2, hi);             // armed: clears timer 1
        rd(3'd1, lo);
        chk("R9/R10 status after timer1 clear", {8'd0, lo}, 16'h02);
        chk("R10 irq off with IE=0 flag", {15'd0, irq_n}, 16'h1);
        rd(3'd4, hi);
        rd(3'd1, lo);
        chk("R9 status after timer2 clear", {8'd0, lo}, 16'h00);

        // R7 gate suspends
        rd(3'd2, v1h); rd(3'd3, v1l);
        idle(9);
        rd(3'd2, v2h); rd(3'd3, v2l);
        chk("R7 gated counter frozen", {v2h, v2l}, {v1h, v1l});

        // R13 non-continuous mode freezes
        wr(3'd0, 8'hCA);
        tmr_gate_n = 3'b000;
        idle(5);
        rd(3'd2, v1h); rd(3'd3, v1l);
        idle(9);
        rd(3'd2, v2h); rd(3'd3, v2l);
        chk("R13 mode 001 counter frozen", {v2h, v2l}, {v1h, v1l});

        // R6 external clock on timer 2
        wr(3'd0, 8'h83);
        wr(3'd1, 8'h01);          // timer 2 external clock
        wr(3'd4, 8'h01); wr(3'd5, 8'h00);
        wr(3'd0, 8'h82);
        idle(6);
        rd(3'd4, hi); rd(3'd5, lo);
        chk("R6 no edges no count", {hi, lo}, 16'h0100);
        for (int p = 0; p < 5; p++) begin
            tmr_clk[1] = 1'b1; idle(3);
            tmr_clk[1] = 1'b0; idle(3);
        end
        idle(5);
        rd(3'd4, hi); rd(3'd5, lo);
        chk("R6/R12 five edges counted", {hi, lo}, 16'h00FB);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule